// File: doc/BRIEF.md
# SQE Test and Jabber Supervisor

This block watches the transmit enable of a 10 Mb/s Ethernet physical layer and drives two outputs: a collision indication and a gate that allows or blocks the line transmitter. After every ordinary packet it waits a short hold-off and then raises the collision output for a brief heartbeat. This tells the MAC that the collision path works.

It also guards against a MAC that keeps transmit enable asserted far too long. Once the enable has been sampled high for more than a trip limit, the transmitter gate closes. The collision output then stays high until the enable has been sampled low for more than a much longer recovery limit. A high sample during recovery starts the recovery count again. A packet that ends in a trip gets no heartbeat.

A mode input selects 10 Mb/s operation. While it is low, both functions are idle and the outputs sit at their neutral values. All four timing values are parameters given in clock cycles, so a bench can shorten them. The state machine has five states:

- `SJS_IDLE`
- `SJS_SEND`: a packet is in progress.
- `SJS_HOLDOFF`: the delay before the heartbeat.
- `SJS_BEAT`: the heartbeat pulse.
- `SJS_LOCK`: the jabber lockout.

Its transitions are:

- IDLE→SEND on a high sample.
- SEND→HOLDOFF on a low sample.
- SEND→LOCK on the trip.
- HOLDOFF→BEAT when the delay ends.
- HOLDOFF→SEND and BEAT→SEND when a new packet pre-empts the heartbeat.
- BEAT→IDLE when the pulse ends.
- LOCK→IDLE on recovery.
- Any state→IDLE when the mode input is low.

Top module: `sqe_jabber_sup`

## Requirements
- R1: During and right after reset, `col_out` is 0 and `tx_gate` is 1.
- R2: A packet that ends without a trip is followed by exactly `SQE_DELAY_CYC` cycles with `col_out` low. Then `col_out` is high for exactly `SQE_PULSE_CYC` cycles. The delay is counted from the first rising edge that samples `tx_en` low, and `tx_gate` stays 1 throughout.
- R3: When `tx_en` is sampled high on `JAB_TRIP_CYC`+1 consecutive edges, `tx_gate` goes to 0 and `col_out` goes to 1 directly after the last of those edges. Exactly `JAB_TRIP_CYC` high samples cause no trip.
- R4: While locked, `col_out` is 1 and `tx_gate` is 0 whatever `tx_en` does.
- R5: The lock ends directly after the edge that gives `JAB_RECOV_CYC`+1 consecutive low samples of `tx_en`. At that point `tx_gate` returns to 1 and `col_out` to 0.
- R6: A single high sample of `tx_en` during the lock restarts the recovery count from zero.
- R7: No heartbeat pulse follows a packet that ended in a trip, neither during the lock nor after recovery.
- R8: A high sample of `tx_en` during the hold-off or the heartbeat cancels the heartbeat, so `col_out` is 0 on the next cycle. That sample counts as the first high sample of a new packet.
- R9: While `mode_10` is 0, `col_out` is 0 and `tx_gate` is 1 in the same cycle. The supervisor returns to idle, so any pending heartbeat or lock is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_10 | input | 1 | High selects 10 Mb/s supervision |
| tx_en | input | 1 | Transmit enable from the MAC |
| col_out | output | 1 | Collision indication: heartbeat pulse or jabber lock |
| tx_gate | output | 1 | High lets the transmitter drive the line |

## Verification
The heartbeat and the start of the next packet can meet in the same cycle. A high sample during the hold-off or the pulse must win, drop the pulse, and count toward the trip limit of the new packet. The random stimulus draws inter-packet gaps from zero up to just past the hold-off plus the pulse length, so new packets start at every point of the heartbeat. Each cycle, a bench model built from the requirements decides whether `col_out` should be high, and the actual output is compared against it.

// File: rtl/sjs_pkg.sv
package sjs_pkg;

    typedef enum logic [2:0] {
        SJS_IDLE    = 3'd0,
        SJS_SEND    = 3'd1,
        SJS_HOLDOFF = 3'd2,
        SJS_BEAT    = 3'd3,
        SJS_LOCK    = 3'd4
    } sjs_state_e;

    function automatic int sjs_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sjs_timer.sv
module sjs_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && (cnt != TOP)) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sjs_fsm.sv
module sjs_fsm
    import sjs_pkg::*;
#(
    parameter int JAB_TRIP_CYC  = 1000000,
    parameter int JAB_RECOV_CYC = 12500000,
    parameter int SQE_DELAY_CYC = 50,
    parameter int SQE_PULSE_CYC = 50,
    parameter int W             = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_10,
    input  logic         tx_en,
    input  logic [W-1:0] cnt,
    output logic         cnt_clr,
    output logic         cnt_inc,
    output logic         col_out,
    output logic         tx_gate
);

    // comparison limits, derived once
    localparam logic [W-1:0] LIM_TRIP  = W'(JAB_TRIP_CYC - 1);
    localparam logic [W-1:0] LIM_RECOV = W'(JAB_RECOV_CYC);
    localparam logic [W-1:0] LIM_DELAY = W'(SQE_DELAY_CYC - 1);
    localparam logic [W-1:0] LIM_PULSE = W'(SQE_PULSE_CYC - 1);

    sjs_state_e state, state_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SJS_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // next state and timer control
    always_comb begin
        state_n = state;
        cnt_clr = 1'b0;
        cnt_inc = 1'b1;
        if (!mode_10) begin
            state_n = SJS_IDLE;
            cnt_clr = 1'b1;
        end else begin
            unique case (state)
                SJS_IDLE: begin
                    cnt_clr = 1'b1;
                    if (tx_en) begin
                        state_n = SJS_SEND;
                    end
                end
                SJS_SEND: begin
                    if (!tx_en) begin
                        state_n = SJS_HOLDOFF;
                        cnt_clr = 1'b1;
                    end else if (cnt == LIM_TRIP) begin
                        state_n = SJS_LOCK;
                        cnt_clr = 1'b1;
                    end
                end
                SJS_HOLDOFF: begin
                    if (tx_en) begin
                        state_n = SJS_SEND;
                        cnt_clr = 1'b1;
                    end else if (cnt == LIM_DELAY) begin
                        state_n = SJS_BEAT;
                        cnt_clr = 1'b1;
                    end
                end
                SJS_BEAT: begin
                    if (tx_en) begin
                        state_n = SJS_SEND;
                        cnt_clr = 1'b1;
                    end else if (cnt == LIM_PULSE) begin
                        state_n = SJS_IDLE;
                        cnt_clr = 1'b1;
                    end
                end
                SJS_LOCK: begin
                    if (tx_en) begin
                        cnt_clr = 1'b1;
                    end else if (cnt == LIM_RECOV) begin
                        state_n = SJS_IDLE;
                        cnt_clr = 1'b1;
                    end
                end
                default: begin
                    state_n = SJS_IDLE;
                    cnt_clr = 1'b1;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        col_out = 1'b0;
        tx_gate = 1'b1;
        if (mode_10) begin
            unique case (state)
                SJS_BEAT: col_out = 1'b1;
                SJS_LOCK: begin
                    col_out = 1'b1;
                    tx_gate = 1'b0;
                end
                default: begin
                    col_out = 1'b0;
                    tx_gate = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/sqe_jabber_sup.sv
module sqe_jabber_sup
    import sjs_pkg::*;
#(
    parameter int JAB_TRIP_CYC  = 1000000,
    parameter int JAB_RECOV_CYC = 12500000,
    parameter int SQE_DELAY_CYC = 50,
    parameter int SQE_PULSE_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_10,
    input  logic tx_en,
    output logic col_out,
    output logic tx_gate
);

    localparam int MAX_LIM = sjs_max(sjs_max(JAB_TRIP_CYC, JAB_RECOV_CYC),
                                     sjs_max(SQE_DELAY_CYC, SQE_PULSE_CYC));
    localparam int CNT_W   = $clog2(MAX_LIM + 2);

    logic [CNT_W-1:0] cnt;
    logic             cnt_clr;
    logic             cnt_inc;

    sjs_timer #(
        .W (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (cnt)
    );

    sjs_fsm #(
        .JAB_TRIP_CYC  (JAB_TRIP_CYC),
        .JAB_RECOV_CYC (JAB_RECOV_CYC),
        .SQE_DELAY_CYC (SQE_DELAY_CYC),
        .SQE_PULSE_CYC (SQE_PULSE_CYC),
        .W             (CNT_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_10 (mode_10),
        .tx_en   (tx_en),
        .cnt     (cnt),
        .cnt_clr (cnt_clr),
        .cnt_inc (cnt_inc),
        .col_out (col_out),
        .tx_gate (tx_gate)
    );

endmodule

// File: rtl/sjs_chk.sv
module sjs_chk #(
    parameter int TRIP  = 1000000,
    parameter int RECOV = 12500000
) (
    input logic clk,
    input logic rst_n,
    input logic mode_10,
    input logic tx_en,
    input logic col_out,
    input logic tx_gate
);

    int unsigned hi_run;
    int unsigned lo_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run <= 0;
            lo_run <= 0;
        end else if (!mode_10) begin
            hi_run <= 0;
            lo_run <= 0;
        end else begin
            hi_run <= tx_en ? ((hi_run < 32'h7fff_ffff) ? hi_run + 1 : hi_run) : 0;
            lo_run <= !tx_en ? ((lo_run < 32'h7fff_ffff) ? lo_run + 1 : lo_run) : 0;
        end
    end

    // R9
    neutral_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_10 |-> (!col_out && tx_gate));

    // R4
    lock_drives_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_gate |-> col_out);

    // R3
    trip_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_gate) |-> (mode_10 && hi_run == TRIP + 1));

    // R5
    recover_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_gate) && mode_10) |-> (lo_run == RECOV + 1));

    // R2
    beat_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(col_out) && tx_gate) |-> !$past(tx_en));

endmodule

bind sqe_jabber_sup sjs_chk #(
    .TRIP  (JAB_TRIP_CYC),
    .RECOV (JAB_RECOV_CYC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_10 (mode_10),
    .tx_en   (tx_en),
    .col_out (col_out),
    .tx_gate (tx_gate)
);

// File: tb/sqe_jabber_sup_tb.sv
module sqe_jabber_sup_tb;

    localparam int TRIP  = 40;
    localparam int RECOV = 60;
    localparam int DLY   = 3;
    localparam int PLS   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_10 = 1'b1;
    logic tx_en = 1'b0;
    logic col_out;
    logic tx_gate;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit run_chk = 1'b0;

    always #10 clk = ~clk;

    sqe_jabber_sup #(
        .JAB_TRIP_CYC  (TRIP),
        .JAB_RECOV_CYC (RECOV),
        .SQE_DELAY_CYC (DLY),
        .SQE_PULSE_CYC (PLS)
    ) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_10 (mode_10),
        .tx_en   (tx_en),
        .col_out (col_out),
        .tx_gate (tx_gate)
    );

    // reference model state, updated at each rising edge
    bit m_lock;
    int m_hi, m_lo, m_post;
    int f_trip, f_lorst, f_unl, f_cancel;

    always @(posedge clk) begin
        cyc++;
        if (f_trip > 0) f_trip--;
        if (f_lorst > 0) f_lorst--;
        if (f_unl > 0) f_unl--;
        if (f_cancel > 0) f_cancel--;
        if (!rst_n || !mode_10) begin
            m_lock = 0; m_hi = 0; m_lo = 0; m_post = 0;
        end else if (m_lock) begin
            if (tx_en) begin
                if (m_lo > 0) f_lorst = RECOV;
                m_lo = 0;
            end else begin
                m_lo++;
                if (m_lo == RECOV + 1) begin
                    m_lock = 0; m_hi = 0; m_post = 0; f_unl = DLY + PLS + 3;
                end
            end
        end else if (tx_en) begin
            if (m_post != 0) f_cancel = 1;
            m_post = 0;
            m_hi++;
            if (m_hi == TRIP + 1) begin
                m_lock = 1; m_lo = 0; m_hi = 0; f_trip = 1;
            end
        end else begin
            if (m_hi > 0) m_post = 1;
            else if (m_post != 0) begin
                m_post++;
                if (m_post > DLY + PLS) m_post = 0;
            end
            m_hi = 0;
        end
    end

    function automatic bit exp_col(bit mode, bit lock, int post);
        if (!mode) return 1'b0;
        return lock || (post >= DLY + 1 && post <= DLY + PLS);
    endfunction

    function automatic bit exp_gate(bit mode, bit lock);
        return !mode || !lock;
    endfunction

    task automatic check(string tag);
        bit ec, eg;
        ec = exp_col(mode_10, m_lock, m_post);
        eg = exp_gate(mode_10, m_lock);
        total++;
        if (col_out !== ec || tx_gate !== eg) begin
            bad++;
            $display("FAIL %s cyc=%0d col=%b/%b gate=%b/%b (actual/expected)",
                     tag, cyc, col_out, ec, tx_gate, eg);
        end
    endtask

    // per-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (run_chk && !done) begin
            if (!mode_10) check("R9");
            else if (m_lock && f_trip > 0) check("R3");
            else if (m_lock && f_lorst > 0) check("R6");
            else if (m_lock) check("R4");
            else if (f_unl == DLY + PLS + 2) check("R5");
            else if (f_unl > 0) check("R7");
            else if (f_cancel > 0) check("R8");
            else check("R2");
        end
    end

    task automatic drive(bit t, bit m, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
            tx_en = t;
            mode_10 = m;
        end
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        // R1: reset state
        total++;
        if (col_out !== 1'b0 || tx_gate !== 1'b1) begin
            bad++;
            $display("FAIL R1 col=%b/0 gate=%b/1", col_out, tx_gate);
        end
        #1 rst_n = 1'b1;
        run_chk = 1'b1;
        drive(0, 1, 3);
        // R2: plain packet then full heartbeat
        drive(1, 1, 5);
        drive(0, 1, DLY + PLS + 4);
        // R3: exactly the limit, no trip
        drive(1, 1, TRIP);
        drive(0, 1, DLY + PLS + 4);
        // R3/R4/R7: one past the limit trips
        drive(1, 1, TRIP + 1);
        drive(1, 1, 5);
        // R6: recovery interrupted by a single high sample
        drive(0, 1, RECOV);
        drive(1, 1, 1);
        // R5/R7: full recovery, no heartbeat afterwards
        drive(0, 1, RECOV + 1);
        drive(0, 1, DLY + PLS + 4);
        // R8: new packet at each point of the hold-off and pulse
        for (int g = 1; g <= DLY + PLS + 1; g++) begin
            drive(1, 1, 3);
            drive(0, 1, g);
        end
        drive(0, 1, DLY + PLS + 2);
        // R9: mode dropped during heartbeat and during lock
        drive(1, 1, 4);
        drive(0, 1, DLY + 1);
        drive(0, 0, 3);
        drive(0, 1, DLY + PLS + 2);
        drive(1, 1, TRIP + 3);
        drive(1, 0, 2);
        drive(0, 1, 4);
        // random mix
        for (int k = 0; k < 300; k++) begin
            int sel, len, gap;
            sel = $urandom_range(0, 9);
            if (sel < 6) len = $urandom_range(1, 10);
            else if (sel < 9) len = $urandom_range(TRIP - 1, TRIP + 2);
            else len = $urandom_range(TRIP + 1, TRIP + 20);
            drive(1, ($urandom_range(0, 49) != 0), len);
            if (m_lock) gap = $urandom_range(RECOV - 2, RECOV + 3);
            else gap = $urandom_range(0, DLY + PLS + 2);
            drive(0, 1, gap);
        end
        drive(0, 1, RECOV + DLY + PLS + 5);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule